// File: doc/BRIEF.md
# SCSI Host Bus-Master DMA Register Block

This block is the control and status register set that steers bus-master DMA for a SCSI host adapter. Software programs a starting byte count, a starting memory address and a starting descriptor-list address, then writes a command word. The low two bits of that word choose an action: start, idle, abort or blast. Start copies the starting values into the working registers, clears the status flags and enables DMA in the SCSI core. Idle disables DMA. Abort asks the core to cancel its active request. Blast has no effect.

While DMA runs, the SCSI core offers data beats. Each beat carries a requested length and a direction. The block rejects a beat whose direction does not match the programmed direction. For an accepted beat, it grants no more than the remaining byte count and returns the current working address in the same cycle. On the clock edge it moves the working count and address on by the granted length. The done flag is raised when the count reaches zero, and also when the core reports that its command has completed.

Bit 24 of a bus-control register chooses how status is cleared. When it is set, software writes ones to clear flags. When it is clear, reading status clears the flags. The memory bus master, the descriptor walk and the SCSI protocol engine are not part of this block; plain request and pulse ports stand in for them.

Top module: `sdma_ctrl_regs`

## Requirements
- R1: After reset: command reads 0, working count reads 0, working address reads 0xFFFFFFFF, status reads 0, working descriptor address reads 0xFFFFFFFD, dma_en is 0 and cancel_req is 0.
- R2: A write to command (byte offset 0x40) with bits [1:0]=3 (start) loads the working count (0x4C) from the start count (0x44), the working address (0x50) from the start address (0x48) and the working descriptor address (0x5C) from the start descriptor address (0x58). It clears status bits [5:0] and sets dma_en on the next cycle.
- R3: A command write with bits [1:0]=0 (idle) clears dma_en. A command write with bits [1:0]=1 (blast) leaves dma_en and the working registers unchanged.
- R4: A command write with bits [1:0]=2 (abort) pulses cancel_req for one cycle if core_req_active is high, and does not pulse it otherwise.
- R5: Command bit 7 set means device-to-memory. A beat whose beat_to_mem differs from command bit 7 gets beat_reject=1 and beat_ack=0, and it leaves the working count and address unchanged.
- R6: An accepted beat returns beat_grant = min(beat_len, working count) and beat_addr = working address in the same cycle. After the edge, the working count has dropped by the grant and the working address has risen by it.
- R7: Status bit 3 (done) is set when an accepted beat leaves the working count at zero.
- R8: A pulse on core_cmd_done forces the working count to 0 and sets done.
- R9: With bus-control (0x70) bit 24 set, a status write clears each of status bits 1, 2 and 3 that is written as one. In this mode a read of status clears nothing.
- R10: With bus-control bit 24 clear, a status read returns the old value and then clears status bits 1, 2 and 3. A status write has no effect.
- R11: A status read returns bit 4 set whenever core_int is high.
- R12: Writes to the working count, working address and working descriptor address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| core_int | input | 1 | Interrupt flag of the SCSI core |
| core_req_active | input | 1 | The SCSI core holds an active request |
| core_cmd_done | input | 1 | The SCSI core has completed its command (pulse) |
| dma_en | output | 1 | DMA enabled towards the SCSI core |
| cancel_req | output | 1 | One-cycle cancel request to the SCSI core |
| beat_req | input | 1 | The SCSI core offers a data beat |
| beat_len | input | 16 | Requested beat length in bytes |
| beat_to_mem | input | 1 | Beat direction: 1 device-to-memory |
| beat_ack | output | 1 | Beat accepted this cycle |
| beat_reject | output | 1 | Beat refused because of direction mismatch |
| beat_grant | output | 16 | Granted length of the accepted beat |
| beat_addr | output | 32 | Memory address for the accepted beat |

## Verification
On every cycle the assertions check several rules. The grant never exceeds the requested length or the remaining count, and the count falls by exactly the grant. A start loads the count and raises dma_en, a completion pulse empties the count and flags done, and a rejected beat leaves the counters frozen. They also check that the core interrupt always shows in status reads and that an abort pulses cancel only while a request is active. Some behaviour needs an ordered sequence, and only the bench scenarios show it. These are: the reset image of the registers, the two status-clear policies (a read that returns old flags and then clears them, write-one-to-clear that ignores zeros), writes to working registers being ignored, and a random run of beat lengths that drains the count to zero.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 8;

    // byte offsets inside the register window
    localparam logic [OFS_W-1:0] OFS_CMD  = 8'h40;
    localparam logic [OFS_W-1:0] OFS_STC  = 8'h44;
    localparam logic [OFS_W-1:0] OFS_SPA  = 8'h48;
    localparam logic [OFS_W-1:0] OFS_WBC  = 8'h4C;
    localparam logic [OFS_W-1:0] OFS_WAC  = 8'h50;
    localparam logic [OFS_W-1:0] OFS_STAT = 8'h54;
    localparam logic [OFS_W-1:0] OFS_SDA  = 8'h58;
    localparam logic [OFS_W-1:0] OFS_WDA  = 8'h5C;
    localparam logic [OFS_W-1:0] OFS_BCTL = 8'h70;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_BLAST = 2'd1,
        ACT_ABORT = 2'd2,
        ACT_START = 2'd3
    } dma_act_e;

    // command word bit positions
    localparam int CMD_DIR_BIT  = 7;
    localparam int CMD_KEEP_W   = 8;

    // status word bit positions
    localparam int ST_PWDN = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_ABT  = 2;
    localparam int ST_DONE = 3;
    localparam int ST_SINT = 4;
    localparam int ST_BLST = 5;
    localparam int ST_W    = 6;

    localparam logic [ST_W-1:0] ST_CLRABLE = ST_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

    localparam int BCTL_W1C_BIT = 24;

    localparam logic [REG_W-1:0] WAC_RST = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] WDA_RST = 32'hFFFF_FFFD;

    typedef struct packed {
        logic     wr_cmd;
        logic     wr_stc;
        logic     wr_spa;
        logic     wr_sda;
        logic     wr_stat;
        logic     wr_bctl;
        logic     rd_stat;
        dma_act_e act;
    } reg_dec_t;

endpackage

// File: rtl/sdma_cmd_decode.sv
module sdma_cmd_decode
    import sdma_pkg::*;
(
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [1:0]       act_bits,
    output reg_dec_t         dec
);
    always_comb begin
        dec         = '0;
        dec.act     = dma_act_e'(act_bits);
        dec.rd_stat = reg_rd && (reg_addr == OFS_STAT);
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_CMD:  dec.wr_cmd  = 1'b1;
                OFS_STC:  dec.wr_stc  = 1'b1;
                OFS_SPA:  dec.wr_spa  = 1'b1;
                OFS_SDA:  dec.wr_sda  = 1'b1;
                OFS_STAT: dec.wr_stat = 1'b1;
                OFS_BCTL: dec.wr_bctl = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/sdma_beat_clamp.sv
module sdma_beat_clamp #(
    parameter int DW   = 32,
    parameter int LENW = 16
) (
    input  logic            beat_req,
    input  logic            beat_to_mem,
    input  logic            cmd_dir,
    input  logic [LENW-1:0] beat_len,
    input  logic [DW-1:0]   wbc,
    input  logic [DW-1:0]   wac,
    output logic            ack,
    output logic            reject,
    output logic [LENW-1:0] grant,
    output logic [DW-1:0]   nxt_wbc,
    output logic [DW-1:0]   nxt_wac,
    output logic            drained
);
    logic [DW-1:0] len_ext;

    always_comb begin
        len_ext = DW'(beat_len);
        ack     = beat_req && (beat_to_mem == cmd_dir);
        reject  = beat_req && (beat_to_mem != cmd_dir);
        if (len_ext < wbc) grant = beat_len;
        else               grant = wbc[LENW-1:0];
        nxt_wbc = wbc - DW'(grant);
        nxt_wac = wac + DW'(grant);
        drained = (nxt_wbc == '0);
    end
endmodule

// File: rtl/sdma_stat_next.sv
module sdma_stat_next
    import sdma_pkg::*;
(
    input  logic [ST_W-1:0] stat_q,
    input  logic            start,
    input  logic            w1c_mode,
    input  logic            wr_stat,
    input  logic            rd_stat,
    input  logic [ST_W-1:0] wdata,
    input  logic            beat_drained,
    input  logic            cmd_done,
    input  logic            core_int,
    output logic [ST_W-1:0] stat_d,
    output logic [ST_W-1:0] stat_view
);
    always_comb begin
        stat_view          = stat_q;
        stat_view[ST_SINT] = stat_q[ST_SINT] | core_int;

        stat_d = stat_q;
        // clears first
        if (start)                  stat_d = '0;
        if (w1c_mode && wr_stat)    stat_d = stat_d & ~(wdata & ST_CLRABLE);
        if (!w1c_mode && rd_stat)   stat_d = stat_d & ~ST_CLRABLE;
        // then sets, so an event in the same cycle is not lost
        if (beat_drained || cmd_done) stat_d[ST_DONE] = 1'b1;
    end
endmodule

// File: rtl/sdma_ctrl_regs.sv
module sdma_ctrl_regs
    import sdma_pkg::*;
#(
    parameter int DW   = 32,
    parameter int LENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [7:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            core_int,
    input  logic            core_req_active,
    input  logic            core_cmd_done,
    output logic            dma_en,
    output logic            cancel_req,
    input  logic            beat_req,
    input  logic [LENW-1:0] beat_len,
    input  logic            beat_to_mem,
    output logic            beat_ack,
    output logic            beat_reject,
    output logic [LENW-1:0] beat_grant,
    output logic [DW-1:0]   beat_addr
);
    logic [DW-1:0]   cmd_q, stc_q, spa_q, sda_q, wbc_q, wac_q, wda_q, bctl_q;
    logic [ST_W-1:0] stat_q, stat_d, stat_view;

    reg_dec_t        dec;
    logic            do_start, do_idle, do_abort;
    logic [DW-1:0]   nxt_wbc, nxt_wac;
    logic            drained;

    sdma_cmd_decode u_dec (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .act_bits (reg_wdata[1:0]),
        .dec      (dec)
    );

    assign do_start = dec.wr_cmd && (dec.act == ACT_START);
    assign do_idle  = dec.wr_cmd && (dec.act == ACT_IDLE);
    assign do_abort = dec.wr_cmd && (dec.act == ACT_ABORT);

    sdma_beat_clamp #(.DW(DW), .LENW(LENW)) u_clamp (
        .beat_req    (beat_req),
        .beat_to_mem (beat_to_mem),
        .cmd_dir     (cmd_q[CMD_DIR_BIT]),
        .beat_len    (beat_len),
        .wbc         (wbc_q),
        .wac         (wac_q),
        .ack         (beat_ack),
        .reject      (beat_reject),
        .grant       (beat_grant),
        .nxt_wbc     (nxt_wbc),
        .nxt_wac     (nxt_wac),
        .drained     (drained)
    );

    assign beat_addr = wac_q;

    sdma_stat_next u_stat (
        .stat_q       (stat_q),
        .start        (do_start),
        .w1c_mode     (bctl_q[BCTL_W1C_BIT]),
        .wr_stat      (dec.wr_stat),
        .rd_stat      (dec.rd_stat),
        .wdata        (reg_wdata[ST_W-1:0]),
        .beat_drained (beat_ack && drained),
        .cmd_done     (core_cmd_done),
        .core_int     (core_int),
        .stat_d       (stat_d),
        .stat_view    (stat_view)
    );

    // programmable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stc_q  <= '0;
            spa_q  <= '0;
            sda_q  <= '0;
            bctl_q <= '0;
        end else begin
            if (dec.wr_cmd)  cmd_q  <= reg_wdata;
            if (dec.wr_stc)  stc_q  <= reg_wdata;
            if (dec.wr_spa)  spa_q  <= reg_wdata;
            if (dec.wr_sda)  sda_q  <= reg_wdata;
            if (dec.wr_bctl) bctl_q <= reg_wdata;
        end
    end

    // working registers: start > completion > beat
    always_ff @(posedge clk) begin
        if (rst) begin
            wbc_q <= '0;
            wac_q <= WAC_RST;
            wda_q <= WDA_RST;
        end else if (do_start) begin
            wbc_q <= stc_q;
            wac_q <= spa_q;
            wda_q <= sda_q;
        end else begin
            if (beat_ack) begin
                wbc_q <= nxt_wbc;
                wac_q <= nxt_wac;
            end
            if (core_cmd_done) wbc_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            dma_en     <= 1'b0;
            cancel_req <= 1'b0;
        end else begin
            stat_q     <= stat_d;
            cancel_req <= do_abort && core_req_active;
            if (do_start)     dma_en <= 1'b1;
            else if (do_idle) dma_en <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_STC:  reg_rdata = stc_q;
            OFS_SPA:  reg_rdata = spa_q;
            OFS_WBC:  reg_rdata = wbc_q;
            OFS_WAC:  reg_rdata = wac_q;
            OFS_STAT: reg_rdata = DW'(stat_view);
            OFS_SDA:  reg_rdata = sda_q;
            OFS_WDA:  reg_rdata = wda_q;
            OFS_BCTL: reg_rdata = bctl_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdma_ctrl_chk.sv
module sdma_ctrl_chk
    import sdma_pkg::*;
#(
    parameter int DW   = 32,
    parameter int LENW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic [7:0]      reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic            core_int,
    input logic            core_req_active,
    input logic            core_cmd_done,
    input logic            dma_en,
    input logic            cancel_req,
    input logic            beat_ack,
    input logic            beat_reject,
    input logic [LENW-1:0] beat_len,
    input logic [LENW-1:0] beat_grant,
    input logic [DW-1:0]   wbc_q,
    input logic [DW-1:0]   wac_q,
    input logic [DW-1:0]   stc_q,
    input logic [ST_W-1:0] stat_q
);
    logic cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && reg_wdata[1:0] == 2'd3) |=> (dma_en && wbc_q == $past(stc_q)));

    a_r3_blast_keeps_en: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && reg_wdata[1:0] == 2'd1) |=> $stable(dma_en));

    a_r4_cancel_on_abort: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && reg_wdata[1:0] == 2'd2 && core_req_active) |=> cancel_req);

    a_r4_no_spurious_cancel: assert property (@(posedge clk) disable iff (rst)
        !(cmd_wr && reg_wdata[1:0] == 2'd2 && core_req_active) |=> !cancel_req);

    a_r5_reject_freezes: assert property (@(posedge clk) disable iff (rst)
        (beat_reject && !cmd_wr && !core_cmd_done) |=> ($stable(wbc_q) && $stable(wac_q)));

    a_r5_ack_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({beat_ack, beat_reject}));

    a_r6_grant_bound: assert property (@(posedge clk) disable iff (rst)
        beat_ack |-> (beat_grant <= beat_len && DW'(beat_grant) <= wbc_q));

    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && !cmd_wr && !core_cmd_done) |=>
        (wbc_q + DW'($past(beat_grant)) == $past(wbc_q) &&
         wac_q == $past(wac_q) + DW'($past(beat_grant))));

    a_r7_done_on_drain: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && DW'(beat_grant) == wbc_q && !cmd_wr) |=> stat_q[ST_DONE]);

    a_r8_completion: assert property (@(posedge clk) disable iff (rst)
        (core_cmd_done && !cmd_wr) |=> (wbc_q == '0 && stat_q[ST_DONE]));

    a_r11_sint_visible: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STAT && core_int) |-> reg_rdata[ST_SINT]);
endmodule

bind sdma_ctrl_regs sdma_ctrl_chk #(.DW(DW), .LENW(LENW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .core_int        (core_int),
    .core_req_active (core_req_active),
    .core_cmd_done   (core_cmd_done),
    .dma_en          (dma_en),
    .cancel_req      (cancel_req),
    .beat_ack        (beat_ack),
    .beat_reject     (beat_reject),
    .beat_len        (beat_len),
    .beat_grant      (beat_grant),
    .wbc_q           (wbc_q),
    .wac_q           (wac_q),
    .stc_q           (stc_q),
    .stat_q          (stat_q)
);

// File: tb/sdma_ctrl_regs_tb.sv
module sdma_ctrl_regs_tb;
    localparam int DW   = 32;
    localparam int LENW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]      reg_addr = 8'h0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            core_int = 1'b0, core_req_active = 1'b0, core_cmd_done = 1'b0;
    logic            dma_en, cancel_req;
    logic            beat_req = 1'b0, beat_to_mem = 1'b0;
    logic [LENW-1:0] beat_len = '0;
    logic            beat_ack, beat_reject;
    logic [LENW-1:0] beat_grant;
    logic [DW-1:0]   beat_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdma_ctrl_regs #(.DW(DW), .LENW(LENW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_int(core_int),
        .core_req_active(core_req_active), .core_cmd_done(core_cmd_done),
        .dma_en(dma_en), .cancel_req(cancel_req), .beat_req(beat_req),
        .beat_len(beat_len), .beat_to_mem(beat_to_mem), .beat_ack(beat_ack),
        .beat_reject(beat_reject), .beat_grant(beat_grant), .beat_addr(beat_addr)
    );

    function automatic logic [LENW-1:0] exp_grant(input logic [LENW-1:0] len,
                                                  input logic [DW-1:0] cnt);
        if (DW'(len) < cnt) return len;
        return cnt[LENW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic beat(input logic [LENW-1:0] len, input logic dir,
                        output logic ack, output logic rej,
                        output logic [LENW-1:0] g, output logic [31:0] ad);
        @(negedge clk);
        beat_req = 1'b1; beat_len = len; beat_to_mem = dir;
        #2 ack = beat_ack; rej = beat_reject; g = beat_grant; ad = beat_addr;
        @(negedge clk);
        beat_req = 1'b0;
    endtask

    task automatic start_dma(input logic [31:0] cnt, input logic [31:0] adr,
                             input logic [31:0] dsc, input logic dir);
        wr(8'h44, cnt);
        wr(8'h48, adr);
        wr(8'h58, dsc);
        wr(8'h40, {24'h0, dir, 7'h03});
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic ack, rej;
        logic [LENW-1:0] g;
        logic [31:0] ad;
        logic [31:0] m_wbc, m_wac;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset image
        rd(8'h40, d); chk(d == 32'h0, "R1 cmd", d, 32'h0);
        rd(8'h4C, d); chk(d == 32'h0, "R1 wbc", d, 32'h0);
        rd(8'h50, d); chk(d == 32'hFFFF_FFFF, "R1 wac", d, 32'hFFFF_FFFF);
        rd(8'h54, d); chk(d == 32'h0, "R1 stat", d, 32'h0);
        rd(8'h5C, d); chk(d == 32'hFFFF_FFFD, "R1 wda", d, 32'hFFFF_FFFD);
        chk(dma_en == 1'b0 && cancel_req == 1'b0, "R1 outputs", {dma_en, cancel_req}, 0);

        // R12 working registers ignore writes
        wr(8'h4C, 32'h1234); wr(8'h50, 32'h5); wr(8'h5C, 32'h7);
        rd(8'h4C, d); chk(d == 32'h0, "R12 wbc", d, 32'h0);
        rd(8'h50, d); chk(d == 32'hFFFF_FFFF, "R12 wac", d, 32'hFFFF_FFFF);
        rd(8'h5C, d); chk(d == 32'hFFFF_FFFD, "R12 wda", d, 32'hFFFF_FFFD);

        // R2 start, device to memory
        start_dma(32'd100, 32'h1000, 32'h2000, 1'b1);
        rd(8'h4C, d); chk(d == 32'd100, "R2 wbc", d, 32'd100);
        rd(8'h50, d); chk(d == 32'h1000, "R2 wac", d, 32'h1000);
        rd(8'h5C, d); chk(d == 32'h2000, "R2 wda", d, 32'h2000);
        chk(dma_en == 1'b1, "R2 dma_en", dma_en, 1);

        // R5 wrong direction
        beat(16'd10, 1'b0, ack, rej, g, ad);
        chk(ack == 1'b0 && rej == 1'b1, "R5 reject", {ack, rej}, 32'h1);
        rd(8'h4C, d); chk(d == 32'd100, "R5 wbc kept", d, 32'd100);

        // R6/R7 random beats that drain the count
        m_wbc = 32'd100; m_wac = 32'h1000;
        for (int i = 0; i < 20; i++) begin
            logic [LENW-1:0] l;
            l = LENW'($urandom_range(1, 40));
            beat(l, 1'b1, ack, rej, g, ad);
            chk(ack == 1'b1, "R6 ack", ack, 1);
            chk(g == exp_grant(l, m_wbc), "R6 grant", g, exp_grant(l, m_wbc));
            chk(ad == m_wac, "R6 addr", ad, m_wac);
            m_wac = m_wac + DW'(exp_grant(l, m_wbc));
            m_wbc = m_wbc - DW'(exp_grant(l, m_wbc));
        end
        rd(8'h4C, d); chk(d == m_wbc, "R6 wbc", d, m_wbc);
        rd(8'h50, d); chk(d == m_wac, "R6 wac", d, m_wac);
        // R10 clear-on-read: first read shows done, second does not
        rd(8'h54, d); chk(d[3] == (m_wbc == 0), "R7 done", d, 32'h8);
        rd(8'h54, d); chk(d[3] == 1'b0, "R10 cleared by read", d, 32'h0);
        // R10 write ignored in this mode
        wr(8'h54, 32'h3F);
        rd(8'h54, d); chk(d == 32'h0, "R10 write ignored", d, 32'h0);

        // R11 core interrupt visible
        @(negedge clk); core_int = 1'b1;
        rd(8'h54, d); chk(d[4] == 1'b1, "R11 sint", d, 32'h10);
        @(negedge clk); core_int = 1'b0;
        rd(8'h54, d); chk(d[4] == 1'b0, "R11 sint off", d, 32'h0);

        // R9 write-one-to-clear mode
        wr(8'h70, 32'h0100_0000);
        start_dma(32'd8, 32'h40, 32'h0, 1'b1);
        beat(16'd20, 1'b1, ack, rej, g, ad);
        chk(g == 16'd8, "R6 clamp", g, 8);
        rd(8'h54, d); chk(d[3] == 1'b1, "R7 done w1c", d, 32'h8);
        rd(8'h54, d); chk(d[3] == 1'b1, "R9 read keeps", d, 32'h8);
        wr(8'h54, 32'h0);
        rd(8'h54, d); chk(d[3] == 1'b1, "R9 zero keeps", d, 32'h8);
        wr(8'h54, 32'h8);
        rd(8'h54, d); chk(d[3] == 1'b0, "R9 one clears", d, 32'h0);

        // R8 completion
        start_dma(32'd50, 32'h80, 32'h0, 1'b1);
        @(negedge clk); core_cmd_done = 1'b1;
        @(negedge clk); core_cmd_done = 1'b0;
        rd(8'h4C, d); chk(d == 32'h0, "R8 wbc", d, 32'h0);
        rd(8'h54, d); chk(d[3] == 1'b1, "R8 done", d, 32'h8);

        // R2 start clears done
        start_dma(32'd30, 32'h90, 32'h0, 1'b1);
        rd(8'h54, d); chk(d == 32'h0, "R2 stat clear", d, 32'h0);

        // R3 blast keeps state, idle disables
        wr(8'h40, 32'h81);
        chk(dma_en == 1'b1, "R3 blast dma_en", dma_en, 1);
        rd(8'h4C, d); chk(d == 32'd30, "R3 blast wbc", d, 32'd30);
        wr(8'h40, 32'h80);
        chk(dma_en == 1'b0, "R3 idle", dma_en, 0);

        // R4 abort without and with an active request
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h82; core_req_active = 1'b0;
        @(posedge clk); #2;
        chk(cancel_req == 1'b0, "R4 no req", cancel_req, 0);
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h82; core_req_active = 1'b1;
        @(posedge clk); #2;
        chk(cancel_req == 1'b1, "R4 cancel", cancel_req, 1);
        @(negedge clk); reg_wr = 1'b0; core_req_active = 1'b0;
        @(posedge clk); #2;
        chk(cancel_req == 1'b0, "R4 one cycle", cancel_req, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule